// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block sits inside an eight-input interrupt controller. It owns the pending-request register, which it updates every clock from the raw interrupt lines. Each input can be set to edge or level sensitivity. It then ranks the unmasked pending requests against a movable priority origin. It reports whether the best of them outranks every interrupt currently in service.

Ranks are counted from the rotation origin. Rank 0 belongs to the input whose number equals the origin, and rank r belongs to input (r + origin) mod N. A lower rank means a higher priority. A pending request is only announced when its rank is strictly lower than the best in-service rank. An optional nested mode, active only on a master controller, ignores the in-service bit of the cascade input, so that a second request from the cascaded controller can get through. The surrounding controller supplies the mask, the in-service bits, the origin and the mode flags. It uses the request-clear strobe to retire edge requests when they are acknowledged.

Top module: `irq_rank_resolver`

## Requirements
- R1: After reset, `req_valid` is 0 and `pend_out` is all zeros. The stored previous-level bits are also 0, so a line that is high in the first clock after reset counts as a rising edge.
- R2: When every pending request is masked, or none is pending, `req_valid` is 0.
- R3: Rank r maps to input number (r + `rot_base`) mod N. With nothing in service, `req_index` names the candidate of lowest rank and `req_valid` is 1.
- R4: `req_valid` is 1 only if the best candidate's rank is strictly lower than the best rank among the in-service bits. An equal or lower-priority candidate gives `req_valid` = 0.
- R5: When `nested_en` = 1 and `is_master` = 1, in-service bit `CASC_IDX` (2 by default) takes no part in the ranking. With either flag at 0, it takes part like any other bit.
- R6: An input with `trig_level` bit = 1 is level sensitive. Its pending bit equals the line value sampled at the previous clock, and `pend_clr` has no effect on it.
- R7: An input with `trig_level` bit = 0 is edge sensitive. Its pending bit is set on a clock where the line is 1 and was 0 at the previous clock. A low line leaves it set. It clears only through its `pend_clr` bit, and a set in the same clock wins over the clear.
- R8: `req_valid` and `req_index` are registered. They reflect the pending, mask, in-service, origin and mode values present at the preceding clock edge, so a line change appears on them two clocks later.
- R9: A masked pending request (`mask` bit = 1) is never named by `req_index` while `req_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | N_IN | Raw interrupt lines |
| trig_level | input | N_IN | Per input: 1 = level sensitive, 0 = edge sensitive |
| pend_clr | input | N_IN | Per input: clear strobe for edge-sensitive pending bits |
| mask | input | N_IN | Per input: 1 = request masked |
| in_service | input | N_IN | In-service bits from the controller |
| rot_base | input | log2(N_IN) | Rotation origin (input holding rank 0) |
| nested_en | input | 1 | Nested mode: ignore cascade in-service bit on a master |
| is_master | input | 1 | This controller is the master of a cascade |
| req_valid | output | 1 | A request outranks everything in service |
| req_index | output | log2(N_IN) | Input number of the winning request |
| pend_out | output | N_IN | Pending-request register |

## Verification
A wrong previous-level bit shows up on `pend_out` as a missed or extra edge one clock after the line moves. It shows up on `req_valid` one clock after that. A wrong rank computation, rotation or in-service comparison appears directly on `req_index` or `req_valid` at the next clock edge. The bench therefore sweeps every candidate pattern under every origin, runs a long pseudo-random mix of masks, in-service sets and mode flags against an arithmetic model, and samples each result exactly two clocks after the lines change.

// File: rtl/irq_rank_pkg.sv
package irq_rank_pkg;
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   localparam int unsigned DEF_INPUTS   = 8;
   localparam int unsigned DEF_CASC_IDX = 2;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
   import irq_rank_pkg::*;
#(
   parameter int unsigned N_IN = DEF_INPUTS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] line_in,
   input  logic [N_IN-1:0] trig_level,
   input  logic [N_IN-1:0] pend_clr,
   output logic [N_IN-1:0] pend_q
);
   logic [N_IN-1:0] prev_q;

   for (genvar i = 0; i < N_IN; i++) begin : g_bit
      trig_e mode;
      logic  rise;
      assign mode = trig_e'(trig_level[i]);
      assign rise = line_in[i] & ~prev_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[i] <= 1'b0;
            pend_q[i] <= 1'b0;
         end else begin
            prev_q[i] <= line_in[i];
            if (mode == TRIG_LEVEL)
               pend_q[i] <= line_in[i];
            else if (rise)
               pend_q[i] <= 1'b1;
            else if (pend_clr[i])
               pend_q[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/irq_rotator.sv
module irq_rotator #(
   parameter int unsigned N_IN = 8,
   localparam int unsigned IW  = $clog2(N_IN)
) (
   input  logic [N_IN-1:0] vec_in,
   input  logic [IW-1:0]   base,
   output logic [N_IN-1:0] vec_out
);
   for (genvar p = 0; p < N_IN; p++) begin : g_rank
      logic [IW-1:0] src;
      assign src        = IW'(p) + base;
      assign vec_out[p] = vec_in[src];
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned N_IN = 8,
   localparam int unsigned LW  = $clog2(N_IN + 1)
) (
   input  logic [N_IN-1:0] vec,
   output logic [LW-1:0]   level
);
   always_comb begin
      level = LW'(N_IN);
      for (int i = N_IN - 1; i >= 0; i--) begin
         if (vec[i]) level = LW'(i);
      end
   end
endmodule

// File: rtl/irq_rank_resolver.sv
module irq_rank_resolver
   import irq_rank_pkg::*;
#(
   parameter int unsigned N_IN           = DEF_INPUTS,
   parameter int unsigned CASC_IDX       = DEF_CASC_IDX,
   parameter bit          NESTED_SUPPORT = 1'b1,
   localparam int unsigned IW            = $clog2(N_IN),
   localparam int unsigned LW            = $clog2(N_IN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] line_in,
   input  logic [N_IN-1:0] trig_level,
   input  logic [N_IN-1:0] pend_clr,
   input  logic [N_IN-1:0] mask,
   input  logic [N_IN-1:0] in_service,
   input  logic [IW-1:0]   rot_base,
   input  logic            nested_en,
   input  logic            is_master,
   output logic            req_valid,
   output logic [IW-1:0]   req_index,
   output logic [N_IN-1:0] pend_out
);
   if (N_IN < 2 || (N_IN & (N_IN - 1)) != 0) begin : g_bad_width
      $error("irq_rank_resolver: N_IN must be a power of two of at least 2");
   end
   if (CASC_IDX >= N_IN) begin : g_bad_casc
      $error("irq_rank_resolver: CASC_IDX out of range");
   end

   logic [N_IN-1:0] pend_q;
   logic [N_IN-1:0] cand;
   logic [N_IN-1:0] isr_eff;
   logic [N_IN-1:0] cand_rot;
   logic [N_IN-1:0] isr_rot;
   logic [LW-1:0]   cand_lvl;
   logic [LW-1:0]   cur_lvl;
   logic            win_d;
   logic [IW-1:0]   idx_d;

   irq_req_latch #(.N_IN(N_IN)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_in    (line_in),
      .trig_level (trig_level),
      .pend_clr   (pend_clr),
      .pend_q     (pend_q)
   );

   assign cand = pend_q & ~mask;

   if (NESTED_SUPPORT) begin : g_nested
      logic [N_IN-1:0] casc_hole;
      assign casc_hole = (nested_en && is_master) ? (N_IN'(1) << CASC_IDX) : '0;
      assign isr_eff   = in_service & ~casc_hole;
   end else begin : g_plain
      logic unused_flags;
      assign unused_flags = nested_en ^ is_master;
      assign isr_eff      = in_service;
   end

   irq_rotator #(.N_IN(N_IN)) u_rot_cand (
      .vec_in  (cand),
      .base    (rot_base),
      .vec_out (cand_rot)
   );

   irq_rotator #(.N_IN(N_IN)) u_rot_isr (
      .vec_in  (isr_eff),
      .base    (rot_base),
      .vec_out (isr_rot)
   );

   irq_prio_enc #(.N_IN(N_IN)) u_enc_cand (
      .vec   (cand_rot),
      .level (cand_lvl)
   );

   irq_prio_enc #(.N_IN(N_IN)) u_enc_isr (
      .vec   (isr_rot),
      .level (cur_lvl)
   );

   assign win_d = (cand_lvl < cur_lvl);
   assign idx_d = cand_lvl[IW-1:0] + rot_base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_index <= '0;
      end else begin
         req_valid <= win_d;
         req_index <= win_d ? idx_d : '0;
      end
   end

   assign pend_out = pend_q;
endmodule

// File: rtl/irq_rank_resolver_chk.sv
module irq_rank_resolver_chk #(
   parameter int unsigned N_IN     = 8,
   parameter int unsigned CASC_IDX = 2,
   localparam int unsigned IW      = $clog2(N_IN)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_IN-1:0] line_in,
   input logic [N_IN-1:0] trig_level,
   input logic [N_IN-1:0] pend_clr,
   input logic [N_IN-1:0] mask,
   input logic [N_IN-1:0] in_service,
   input logic            nested_en,
   input logic            is_master,
   input logic            req_valid,
   input logic [IW-1:0]   req_index,
   input logic [N_IN-1:0] pend_out
);
   logic            armed;
   logic [N_IN-1:0] cand_q, isr_q, line_q, lvl_q, held_q;
   logic            hole_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         cand_q <= '0;
         isr_q  <= '0;
         line_q <= '0;
         lvl_q  <= '0;
         held_q <= '0;
         hole_q <= 1'b0;
      end else begin
         armed  <= 1'b1;
         cand_q <= pend_out & ~mask;
         isr_q  <= in_service;
         line_q <= line_in;
         lvl_q  <= trig_level;
         held_q <= pend_out & ~trig_level & ~pend_clr;
         hole_q <= nested_en & is_master;
      end
   end

   // R2: nothing unmasked pending means no request
   p_empty_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && cand_q == '0) |-> !req_valid);

   // R9: the winner was an unmasked pending input
   p_winner_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && req_valid) |-> cand_q[req_index]);

   // R4: the winner is not itself in service (except the ignored cascade bit)
   p_winner_not_in_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && req_valid && !(hole_q && req_index == IW'(CASC_IDX))) |-> !isr_q[req_index]);

   // R6: level inputs follow the previous-clock line value
   p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (((pend_out ^ line_q) & lvl_q) == '0));

   // R7: edge pending bits stay set until cleared
   p_edge_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((pend_out & held_q) == held_q));
endmodule

bind irq_rank_resolver irq_rank_resolver_chk #(.N_IN(N_IN), .CASC_IDX(CASC_IDX)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_in    (line_in),
   .trig_level (trig_level),
   .pend_clr   (pend_clr),
   .mask       (mask),
   .in_service (in_service),
   .nested_en  (nested_en),
   .is_master  (is_master),
   .req_valid  (req_valid),
   .req_index  (req_index),
   .pend_out   (pend_out)
);

// File: tb/sim_irq_rank_resolver.sv
`timescale 1ns/1ps
module sim_irq_rank_resolver;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] line_in = '0, trig_level = 8'hFF, pend_clr = '0;
   logic [7:0] mask = '0, in_service = '0;
   logic [2:0] rot_base = '0;
   logic       nested_en = 1'b0, is_master = 1'b0;
   logic       req_valid;
   logic [2:0] req_index;
   logic [7:0] pend_out;

   int checks = 0;
   int fails  = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #5 clk = ~clk;

   irq_rank_resolver u0 (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .trig_level(trig_level),
      .pend_clr(pend_clr), .mask(mask), .in_service(in_service),
      .rot_base(rot_base), .nested_en(nested_en), .is_master(is_master),
      .req_valid(req_valid), .req_index(req_index), .pend_out(pend_out)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int rank_of(input logic [7:0] v, input int base);
      for (int p = 0; p < 8; p++) if (v[(p + base) % 8]) return p;
      return 8;
   endfunction

   // returns {valid, index}
   function automatic logic [3:0] model(input logic [7:0] pend, input logic [7:0] msk,
                                        input logic [7:0] isr, input int base,
                                        input logic nest, input logic mst);
      int cl, il;
      logic [7:0] isr_e;
      isr_e = (nest && mst) ? (isr & 8'hFB) : isr;
      cl = rank_of(pend & ~msk, base);
      il = rank_of(isr_e, base);
      if (cl < il) return {1'b1, 3'((cl + base) % 8)};
      return 4'b0000;
   endfunction

   task automatic check_out(input string req, input logic [3:0] exp);
      chk(req, {4'b0, req_valid, req_index}, {4'b0, exp});
   endtask

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      logic [31:0] x;
      x = s ^ (s << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1 valid", {7'b0, req_valid}, 8'h00);
      chk("R1 pend", pend_out, 8'h00);
      rst_n = 1'b1;
      step(1);
      chk("R1 idle after reset", {7'b0, req_valid}, 8'h00);

      // R8: latency, line -> pend after one edge, -> valid after two
      line_in = 8'h10;
      step(1);
      chk("R8 pend after one edge", pend_out, 8'h10);
      chk("R8 valid not yet", {7'b0, req_valid}, 8'h00);
      step(1);
      check_out("R8 valid after two edges", 4'b1100);

      // R2: everything masked
      mask = 8'hFF;
      line_in = 8'hA5;
      step(2);
      check_out("R2 all masked", 4'b0000);
      mask = 8'h00;
      line_in = 8'h00;
      step(2);
      check_out("R2 nothing pending", 4'b0000);

      // R3: exhaustive candidate sweep under every origin, nothing in service
      for (int b = 0; b < 8; b++) begin
         for (int c = 0; c < 256; c++) begin
            rot_base = 3'(b);
            line_in = 8'(c);
            step(2);
            check_out("R3 rotation", model(8'(c), 8'h00, 8'h00, b, 1'b0, 1'b0));
         end
      end

      // R4: equal rank is not enough
      rot_base = 3'd0;
      line_in = 8'h08;
      in_service = 8'h08;
      step(2);
      check_out("R4 equal rank blocked", 4'b0000);
      in_service = 8'h10;
      step(2);
      check_out("R4 higher rank wins", 4'b1011);
      rot_base = 3'd4;
      step(2);
      check_out("R4 rotation reverses order", 4'b0000);

      // R5: nested mode on master
      rot_base = 3'd0;
      line_in = 8'h04;
      in_service = 8'h04;
      nested_en = 1'b1;
      is_master = 1'b1;
      step(2);
      check_out("R5 nested master ignores cascade bit", 4'b1010);
      is_master = 1'b0;
      step(2);
      check_out("R5 nested slave keeps bit", 4'b0000);
      is_master = 1'b1;
      nested_en = 1'b0;
      step(2);
      check_out("R5 plain master keeps bit", 4'b0000);

      // R9: masked best candidate skipped in favour of next
      in_service = 8'h00;
      line_in = 8'h41;
      mask = 8'h01;
      step(2);
      check_out("R9 masked skipped", 4'b1110);
      mask = 8'h00;

      // R4/R5/R9: pseudo-random sweep against the model
      for (int k = 0; k < 3000; k++) begin
         logic [3:0] e;
         seed = next_rand(seed);
         line_in = seed[7:0];
         mask = seed[15:8] & seed[23:16];
         seed = next_rand(seed);
         in_service = seed[7:0] & seed[15:8];
         rot_base = seed[18:16];
         nested_en = seed[20];
         is_master = seed[21];
         step(2);
         e = model(line_in, mask, in_service, int'(rot_base), nested_en, is_master);
         check_out("R4 random rank vs in-service", e);
      end

      // R6: level mode follows line, clear ignored
      mask = 8'h00; in_service = 8'h00; rot_base = 3'd0;
      nested_en = 1'b0; is_master = 1'b0;
      line_in = 8'h02;
      pend_clr = 8'h02;
      step(1);
      chk("R6 level set, clear ignored", pend_out, 8'h02);
      pend_clr = 8'h00;
      line_in = 8'h00;
      step(1);
      chk("R6 level low clears", pend_out, 8'h00);

      // R7: edge mode on input 5
      trig_level = 8'hDF;
      step(1);
      line_in = 8'h20;
      step(1);
      chk("R7 rising edge sets", pend_out, 8'h20);
      line_in = 8'h00;
      step(2);
      chk("R7 low line keeps bit", pend_out, 8'h20);
      check_out("R7 edge request wins", 4'b1101);
      pend_clr = 8'h20;
      step(1);
      pend_clr = 8'h00;
      chk("R7 clear strobe clears", pend_out, 8'h00);
      line_in = 8'h20;
      step(1);
      chk("R7 second rising edge sets", pend_out, 8'h20);
      pend_clr = 8'h20;
      step(1);
      pend_clr = 8'h00;
      chk("R7 held-high line cleared", pend_out, 8'h00);
      step(2);
      chk("R7 held-high line no re-set", pend_out, 8'h00);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule